// File: doc/BRIEF.md
# Serial Quad DAC Register Front End

This block is the digital front end of a four-channel, 8-bit DAC that is programmed over a three-wire serial link with a separate output-update strobe. The serial clock, data, load and update pins reach the block asynchronously. The block samples them in a fast system clock. A data bit is taken on every falling edge of the serial clock, most significant bit first. The block keeps only the most recent 11 bits, however many edges arrive.

A falling edge on the load pin decodes the held word. Its top two bits pick a channel, the next bit picks the gain range, and the low eight bits give the code. These are written into that channel's input latch. A falling edge on the update pin copies all four input latches, gain flags included, into the output registers at once. The output registers drive the converter.

Each accepted load and each transfer is reported with a one-cycle pulse. A load that arrives before 11 bits have been clocked in since the previous load is dropped, and a frame-error flag is raised.

Top module: `dacif_top`

## Requirements
- R1: After reset every output code is zero, every gain flag is 0 (x1), both pulses are low and the frame-error flag is low.
- R2: A bit is captured on each falling edge of the serial clock, MSB first. In an 11-bit word, bits [10:9] are the channel select, bit [8] is the gain bit and bits [7:0] are the code.
- R3: When more than 11 bits arrive before a load, only the last 11 are used.
- R4: A select value of n (00, 01, 10, 11) addresses channel n. Channel n's output code appears on outCode[8n+7:8n].
- R5: A gain bit of 1 sets outGain[n] (x2) after transfer, and a gain bit of 0 clears it (x1).
- R6: A falling edge on the load pin writes only the addressed input latch. The outputs do not change until a transfer. Each accepted load gives exactly one single-cycle loadPulse.
- R7: A falling edge on the update pin copies all four input latches to the outputs in the same cycle. Channels that were not loaded keep their values. Each transfer gives exactly one single-cycle xferPulse. The outputs change only in a cycle where xferPulse is high.
- R8: A load that arrives after fewer than 11 bits since the last load is ignored, with no effect on any channel and no loadPulse, and it sets frameErr. The next accepted load clears frameErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, asynchronous; bit taken on falling edge |
| serData | input | 1 | Serial data, asynchronous |
| serLoad | input | 1 | Load strobe, asynchronous; falling edge writes an input latch |
| serUpdate | input | 1 | Update strobe, asynchronous; falling edge transfers to outputs |
| outCode | output | NUM_CH*CODE_W | Output codes, channel n at [CODE_W*n +: CODE_W] |
| outGain | output | NUM_CH | Gain flags per channel, 1 = x2 |
| loadPulse | output | 1 | One-cycle pulse on each accepted load |
| xferPulse | output | 1 | One-cycle pulse on each transfer |
| frameErr | output | 1 | Set by a short-frame load, cleared by an accepted load |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit codes and two synchronizer stages. That size is small enough to sweep every channel against both gain values and sixteen spread-out codes, with the expected latches and outputs modelled arithmetically. The same small frame makes the long-frame and short-frame corners cheap to reach. Padding junk bits ahead of a word and cutting a word to five bits show the discard and error paths, and loading a single channel shows that the others hold across a transfer.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Strobes the control sends to the datapath, one system clock wide.
  typedef struct packed {
    logic shift;    // take dataBit into the shift register
    logic dataBit;  // synchronized serial data
    logic load;     // write the addressed input latch
    logic xfer;     // copy all input latches to the outputs
  } ctrlStrobes_t;

endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int FRAME_W     = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serData,
  input  logic         serLoad,
  input  logic         serUpdate,
  output ctrlStrobes_t strobes,
  output logic         frameErr
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int PIN_N = 4;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  // pin order: 0 clock, 1 data, 2 load, 3 update
  logic [SYNC_STAGES-1:0][PIN_N-1:0] syncPipe;
  logic [PIN_N-1:0] pinNow, pinPrev;
  logic [CNT_W-1:0] bitCnt;
  logic clkFall, loadFall, updFall;

  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[st] <= '0;
        else if (st == 0) syncPipe[st] <= {serUpdate, serLoad, serData, serClk};
        else syncPipe[st] <= syncPipe[st-1];
      end
    end
  endgenerate

  assign pinNow = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinNow;
  end

  assign clkFall  = pinPrev[0] & ~pinNow[0];
  assign loadFall = pinPrev[2] & ~pinNow[2];
  assign updFall  = pinPrev[3] & ~pinNow[3];

  // bits seen since the last load, saturating at one frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         bitCnt <= '0;
    else if (loadFall)                 bitCnt <= '0;
    else if (clkFall && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         frameErr <= 1'b0;
    else if (loadFall) frameErr <= (bitCnt < FULL);
  end

  always_comb begin
    strobes.shift   = clkFall;
    strobes.dataBit = pinNow[1];
    strobes.load    = loadFall && (bitCnt >= FULL);
    strobes.xfer    = updFall;
  end

endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  output logic [NUM_CH*CODE_W-1:0] outCode,
  output logic [NUM_CH-1:0]        outGain,
  output logic                     loadPulse,
  output logic                     xferPulse
);

  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int FRAME_W = SEL_W + 1 + CODE_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [SEL_W-1:0]   wordSel;
  logic               wordGain;
  logic [CODE_W-1:0]  wordCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobes.shift) shiftReg <= {shiftReg[FRAME_W-2:0], strobes.dataBit};
  end

  assign wordSel  = shiftReg[FRAME_W-1 -: SEL_W];
  assign wordGain = shiftReg[CODE_W];
  assign wordCode = shiftReg[CODE_W-1:0];

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [CODE_W-1:0] latCode;
      logic              latGain;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          latCode <= '0;
          latGain <= 1'b0;
        end else if (strobes.load && wordSel == SEL_W'(ch)) begin
          latCode <= wordCode;
          latGain <= wordGain;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outCode[ch*CODE_W +: CODE_W] <= '0;
          outGain[ch]                  <= 1'b0;
        end else if (strobes.xfer) begin
          outCode[ch*CODE_W +: CODE_W] <= latCode;
          outGain[ch]                  <= latGain;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPulse <= 1'b0;
      xferPulse <= 1'b0;
    end else begin
      loadPulse <= strobes.load;
      xferPulse <= strobes.xfer;
    end
  end

endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     serLoad,
  input  logic                     serUpdate,
  output logic [NUM_CH*CODE_W-1:0] outCode,
  output logic [NUM_CH-1:0]        outGain,
  output logic                     loadPulse,
  output logic                     xferPulse,
  output logic                     frameErr
);

  localparam int FRAME_W = $clog2(NUM_CH) + 1 + CODE_W;

  ctrlStrobes_t strobes;

  dacif_ctrl #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serUpdate(serUpdate),
    .strobes(strobes), .frameErr(frameErr)
  );

  dacif_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .outCode(outCode), .outGain(outGain),
    .loadPulse(loadPulse), .xferPulse(xferPulse)
  );

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH*CODE_W-1:0] outCode,
  input logic [NUM_CH-1:0]        outGain,
  input logic                     loadPulse,
  input logic                     xferPulse,
  input logic                     frameErr
);

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse); // R6

  AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xferPulse |=> !xferPulse); // R7

  AST_OUT_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(outCode) && $stable(outGain)) |-> xferPulse); // R7

  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !loadPulse); // R8

  AST_ERR_CLEAR_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameErr) |-> loadPulse); // R8

  AST_LOAD_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> !frameErr); // R8

endmodule

bind dacif_top dacif_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .outCode(outCode), .outGain(outGain),
  .loadPulse(loadPulse), .xferPulse(xferPulse), .frameErr(frameErr)
);

// File: tb/dacif_top_tb_top.sv
module dacif_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int GAP = 5;

  logic clk = 0, rstN = 0;
  logic serClk = 0, serData = 0, serLoad = 1, serUpdate = 1;
  logic [NCH*CW-1:0] outCode;
  logic [NCH-1:0] outGain;
  logic loadPulse, xferPulse, frameErr;

  int nTests = 0, nFail = 0;
  int loadCnt = 0, xferCnt = 0;
  logic [CW-1:0] latC [NCH];
  logic          latG [NCH];
  logic [CW-1:0] expC [NCH];
  logic          expG [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dacif_top dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serUpdate(serUpdate), .outCode(outCode),
    .outGain(outGain), .loadPulse(loadPulse), .xferPulse(xferPulse),
    .frameErr(frameErr)
  );

  always @(posedge clk) begin
    if (loadPulse) loadCnt++;
    if (xferPulse) xferCnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    serData = b; serClk = 1; waitClk(GAP);
    serClk = 0; waitClk(GAP);
  endtask

  // sends the n low bits of w, MSB first
  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 0; waitClk(GAP); serLoad = 1; waitClk(GAP);
  endtask

  task automatic pulseUpdate();
    serUpdate = 0; waitClk(GAP); serUpdate = 1; waitClk(GAP);
  endtask

  task automatic checkOuts(input string req);
    logic [NCH*CW-1:0] ec;
    logic [NCH-1:0] eg;
    for (int c = 0; c < NCH; c++) begin
      ec[c*CW +: CW] = expC[c];
      eg[c] = expG[c];
    end
    check(outCode === ec, req, outCode, ec);
    check(outGain === eg, req, outGain, eg);
  endtask

  // full load of one channel through the serial link
  task automatic writeChan(input int ch, input bit g, input logic [CW-1:0] code, input int junk);
    int lc;
    logic [10:0] w;
    w = {ch[1:0], g, code};
    if (junk > 0) sendBits(32'h5A5A5A5A ^ ~{21'd0, w}, junk);
    sendBits({21'd0, w}, 11);
    lc = loadCnt;
    pulseLoad();
    latC[ch] = code; latG[ch] = g;
    check(loadCnt == lc + 1, "R6 load pulse count", loadCnt, lc + 1);
    check(frameErr == 0, "R8 err clear on valid load", frameErr, 0);
    checkOuts("R6 outputs held before transfer");
  endtask

  task automatic doXfer();
    int xc;
    xc = xferCnt;
    pulseUpdate();
    for (int c = 0; c < NCH; c++) begin expC[c] = latC[c]; expG[c] = latG[c]; end
    check(xferCnt == xc + 1, "R7 xfer pulse count", xferCnt, xc + 1);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin latC[c] = 0; latG[c] = 0; expC[c] = 0; expG[c] = 0; end
    waitClk(3);
    rstN = 1;
    waitClk(GAP);
    // R1 reset state
    checkOuts("R1 reset");
    check(frameErr == 0 && loadPulse == 0 && xferPulse == 0, "R1 flags", {frameErr, loadPulse, xferPulse}, 0);
    check(loadCnt == 0 && xferCnt == 0, "R1 no pulses", loadCnt + xferCnt, 0);

    // R2 R4 R5 sweep: every channel, both gains, sixteen codes
    for (int ch = 0; ch < NCH; ch++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 16; k++) begin
          logic [CW-1:0] code;
          code = CW'((k * 37 + ch * 11 + g * 101) & 8'hFF);
          writeChan(ch, g[0], code, 0);
          doXfer();
          checkOuts("R2 R4 R5 sweep");
        end

    // R3: extra leading bits discarded
    for (int j = 1; j <= 6; j++) begin
      writeChan(j % NCH, j[0], CW'(j * 41), j + 2);
      doXfer();
      checkOuts("R3 long frame");
    end

    // R7: load all channels, transfer once; then only one channel, others hold
    for (int ch = 0; ch < NCH; ch++) writeChan(ch, ch[0], CW'(8'hC0 + ch), 0);
    doXfer();
    checkOuts("R7 simultaneous transfer");
    writeChan(2, 1'b0, 8'h3C, 0);
    doXfer();
    checkOuts("R7 untouched channels hold");
    doXfer();
    checkOuts("R7 repeat transfer");

    // R8: short frame ignored, error set, then cleared
    begin
      int lc;
      sendBits({21'd0, 2'd1, 1'b1, 8'hEE}, 5);
      lc = loadCnt;
      pulseLoad();
      check(frameErr == 1, "R8 err set", frameErr, 1);
      check(loadCnt == lc, "R8 no load pulse", loadCnt, lc);
      doXfer();
      checkOuts("R8 short frame no effect");
      writeChan(1, 1'b1, 8'h81, 0);
      doXfer();
      checkOuts("R8 recover");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule